// File: doc/BRIEF.md
# MDIO management master

This block is a management-bus master that runs one Clause 22 read or write frame at a time to an external PHY. Software prepares a single command word holding the opcode, the PHY and register addresses and, for writes, the data. It sets the start flag in that word and polls until the flag drops. On a read, the returned word carries the sixteen data bits and a flag that tells whether a PHY answered.

A control word switches the master on and off and sets the MDC rate. MDC runs at the functional clock divided by (divider + 1). The control word also reports whether a frame is on the wire and holds a sticky flag that records reads nobody answered. Both words sit behind a plain 32-bit register port. Writes take effect at the clock edge and reads are combinational.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0x800000FF (idle set, enable clear, divider 0xFF) and the command word reads 0. MDC is low and MDIO is not driven.
- R2: The command word sits at offset 0x4. Its fields are: bit 31 start (GO), bit 30 write-select (1 write, 0 read), bit 29 acknowledge, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data.
- R3: A write frame goes out MSB first as 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits. MDIO changes only at MDC falling edges.
- R4: A read frame uses opcode 10. The master stops driving MDIO from the first turnaround bit to the end of the frame. It samples MDIO at each MDC rising edge and places the 16 data bits in bits 15:0.
- R5: The acknowledge bit is 1 after a read only if MDIO was low during the second turnaround bit. A read from an absent PHY returns acknowledge 0.
- R6: GO stays 1 for the whole transaction and clears itself when the frame ends. The idle bit reads 0 while a frame is on the wire.
- R7: A write to the command word while GO is 1 is ignored. The fields stay unchanged and no further frame starts.
- R8: MDC has a period of (divider + 1) clock cycles, and a divider of 0 acts as 1. MDC is low whenever no frame runs.
- R9: With enable clear, a command with GO waits: GO stays 1, idle stays 1 and MDC does not toggle. It starts once enable is set. Clearing enable during a frame lets that frame finish.
- R10: When fault-enable is set, a read without acknowledge sets the fault flag. Writing 1 to the fault bit clears it. With fault-enable clear, the flag is not set.
- R11: The control word sits at offset 0x0. Its fields are: bit 31 idle (read-only), bit 30 enable, bit 19 fault, bit 18 fault-enable, bits 15:0 divider. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sensed on the pin |

## Verification
The bench builds the block with its default parameters: a 4-bit address, a 16-bit divider and a reset divider of 0xFF. It then reprograms the divider at run time to 0, 1, 3, 6 and 255. The divider of 0 and 1 cases push MDC to the shortest two-cycle period. In that period the turnaround release and the data sampling fall on adjacent clock edges. The 255 case confirms the reset rate, and 6 gives an uneven high/low split. A PHY responder at one address checks write frames bit by bit and answers reads, while other addresses show the absent-PHY path.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    // Frame geometry, bit index 0 is the first bit on the wire
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;
    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // Command word field positions
    localparam int CMD_GO  = 31;
    localparam int CMD_WR  = 30;
    localparam int CMD_ACK = 29;
    localparam int CMD_REG = 21;
    localparam int CMD_PHY = 16;

    // Control word field positions
    localparam int CTL_IDLE = 31;
    localparam int CTL_EN   = 30;
    localparam int CTL_FLT  = 19;
    localparam int CTL_FEN  = 18;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [DATA_W-1:0]     rdat;
        logic                  ack;
    } seq_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_ev,
    output logic             fall_ev
);
    localparam int PER_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_state_t;

    gen_state_t s_d, s_q;

    logic [DIV_W-1:0] div_eff;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] low_len;

    // A divider of zero cannot give a full MDC cycle, so it runs as one
    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign per     = {1'b0, div_eff} + PER_W'(1);
    assign low_len = per - (per >> 1);

    // Events announce the edge at which MDC will change
    assign rise_ev = en && ({1'b0, s_q.cnt} == low_len - PER_W'(1));
    assign fall_ev = en && (s_q.cnt == div_eff);
    assign mdc     = s_q.mdc;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else begin
            s_d.cnt = (s_q.cnt == div_eff) ? '0 : s_q.cnt + DIV_W'(1);
            s_d.mdc = ({1'b0, s_d.cnt} >= low_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    is_wr,
    input  logic [PHY_AW-1:0]       phy,
    input  logic [REG_AW-1:0]       regad,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    rise_ev,
    input  logic                    fall_ev,
    input  logic                    mdio_i,
    output logic                    busy,
    output logic                    is_rd,
    output logic [IDX_W-1:0]        idx,
    output logic                    mdio_o,
    output logic                    mdio_oe,
    output logic                    done,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_ack
);
    seq_state_t s_d, s_q;
    logic [FRAME_BITS-1:0] frame;

    assign frame = {{PRE_BITS{1'b1}}, SOF_CODE,
                    is_wr ? OP_WRITE : OP_READ,
                    phy, regad, TA_WRITE,
                    is_wr ? wdata : {DATA_W{1'b0}}};

    assign busy    = s_q.busy;
    assign is_rd   = s_q.rd;
    assign idx     = s_q.idx;
    assign mdio_o  = s_q.sh[FRAME_BITS-1];
    assign mdio_oe = s_q.busy && !(s_q.rd && (int'(s_q.idx) >= TA_FIRST));
    assign done    = s_q.busy && fall_ev && (int'(s_q.idx) == FRAME_BITS - 1);
    assign rd_data = s_q.rdat;
    assign rd_ack  = s_q.ack;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.rd   = !is_wr;
            s_d.idx  = '0;
            s_d.sh   = frame;
            s_d.ack  = 1'b0;
        end else if (s_q.busy) begin
            if (rise_ev && s_q.rd) begin
                if (int'(s_q.idx) == TA_SECOND) begin
                    s_d.ack = !mdio_i;
                end
                if (int'(s_q.idx) >= DATA_FIRST) begin
                    s_d.rdat = {s_q.rdat[DATA_W-2:0], mdio_i};
                end
            end
            if (fall_ev) begin
                s_d.sh = {s_q.sh[FRAME_BITS-2:0], 1'b0};
                if (int'(s_q.idx) == FRAME_BITS - 1) begin
                    s_d.busy = 1'b0;
                    s_d.idx  = '0;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DIV_W    = 16,
    parameter logic [DIV_W-1:0]  DIV_RST  = DIV_W'(8'hFF),
    parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        logic              en;
        logic              fault;
        logic              fault_en;
        logic [DIV_W-1:0]  div;
        logic              go;
        logic              wr;
        logic              ack;
        logic [REG_AW-1:0] rega;
        logic [PHY_AW-1:0] phy;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t r_d, r_q;

    logic              eng_busy;
    logic              eng_is_rd;
    logic [IDX_W-1:0]  eng_idx;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              eng_ack;
    logic              eng_start;
    logic              rise_ev;
    logic              fall_ev;
    logic              ctrl_we;
    logic              cmd_we;
    logic [15:0]       div16;
    logic              unused_wbits;

    // Plain views of register state for the bound checker
    logic              go_w;
    logic              wr_w;
    logic [REG_AW-1:0] rega_w;
    logic [PHY_AW-1:0] phy_w;
    logic [DIV_W-1:0]  div_w;

    assign go_w   = r_q.go;
    assign wr_w   = r_q.wr;
    assign rega_w = r_q.rega;
    assign phy_w  = r_q.phy;
    assign div_w  = r_q.div;

    assign ctrl_we      = bus_we && (bus_addr == CTRL_OFS);
    assign cmd_we       = bus_we && (bus_addr == CMD_OFS);
    assign eng_start    = r_q.go && r_q.en && !eng_busy;
    assign div16        = 16'(r_q.div);
    assign unused_wbits = ^bus_wdata[29:26];

    always_comb begin
        r_d = r_q;
        if (ctrl_we) begin
            r_d.en       = bus_wdata[CTL_EN];
            r_d.fault_en = bus_wdata[CTL_FEN];
            r_d.div      = bus_wdata[DIV_W-1:0];
            if (bus_wdata[CTL_FLT]) begin
                r_d.fault = 1'b0;
            end
        end
        if (cmd_we && !r_q.go) begin
            r_d.go   = bus_wdata[CMD_GO];
            r_d.wr   = bus_wdata[CMD_WR];
            r_d.rega = bus_wdata[CMD_REG +: REG_AW];
            r_d.phy  = bus_wdata[CMD_PHY +: PHY_AW];
            r_d.data = bus_wdata[DATA_W-1:0];
            r_d.ack  = 1'b0;
        end
        if (eng_done) begin
            r_d.go = 1'b0;
            if (r_q.wr) begin
                r_d.ack = 1'b0;
            end else begin
                r_d.data = eng_rdata;
                r_d.ack  = eng_ack;
                if (!eng_ack && r_q.fault_en) begin
                    r_d.fault = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIV_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (bus_addr == CTRL_OFS) begin
            bus_rdata = {!eng_busy, r_q.en, 10'b0, r_q.fault, r_q.fault_en, 2'b0, div16};
        end else if (bus_addr == CMD_OFS) begin
            bus_rdata = {r_q.go, r_q.wr, r_q.ack, 3'b0, r_q.rega, r_q.phy, r_q.data};
        end else begin
            bus_rdata = '0;
        end
    end

    mdio_mdc_gen #(
        .DIV_W (DIV_W)
    ) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (eng_busy),
        .div     (r_q.div),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .is_wr   (r_q.wr),
        .phy     (r_q.phy),
        .regad   (r_q.rega),
        .wdata   (r_q.data),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .mdio_i  (mdio_i),
        .busy    (eng_busy),
        .is_rd   (eng_is_rd),
        .idx     (eng_idx),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (eng_done),
        .rd_data (eng_rdata),
        .rd_ack  (eng_ack)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              go,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              is_rd,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [DIV_W-1:0]  div,
    input logic              cmd_we,
    input logic              wr,
    input logic [REG_AW-1:0] rega,
    input logic [PHY_AW-1:0] phy
);
    logic [DIV_W+1:0] cyc_q;
    logic             mdc_prev_q;
    logic             seen_q;
    logic [DIV_W+1:0] per_exp;

    assign per_exp = (div == '0) ? (DIV_W+2)'(2) : (DIV_W+2)'(div) + (DIV_W+2)'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            mdc_prev_q <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            mdc_prev_q <= mdc;
            if (mdc && !mdc_prev_q) begin
                cyc_q  <= (DIV_W+2)'(1);
                seen_q <= 1'b1;
            end else begin
                cyc_q <= cyc_q + (DIV_W+2)'(1);
                if (!busy) begin
                    seen_q <= 1'b0;
                end
            end
        end
    end

    // R6: a frame in progress always has its start flag raised
    p_go_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> go);

    // R6: the start flag drops only as a frame ends
    p_go_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> $past(busy));

    // R7: command fields are frozen against writes while GO is set
    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd_we) |=> ($stable(rega) && $stable(phy) && $stable(wr)));

    // R4: master releases the line from the turnaround onward on reads
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rd && (int'(bit_idx) >= TA_FIRST)) |-> !mdio_oe);

    // R8: MDC rests low between frames
    p_mdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R8: consecutive MDC rising edges are divider+1 cycles apart
    p_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && !mdc_prev_q && seen_q) |-> (cyc_q == per_exp));
endmodule

bind mdio_master mdio_master_chk #(
    .DIV_W (DIV_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (eng_busy),
    .go      (go_w),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .is_rd   (eng_is_rd),
    .bit_idx (eng_idx),
    .div     (div_w),
    .cmd_we  (cmd_we),
    .wr      (wr_w),
    .rega    (rega_w),
    .phy     (phy_w)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
    localparam logic [3:0] A_CTRL   = 4'h0;
    localparam logic [3:0] A_CMD    = 4'h4;
    localparam logic [4:0] PHY_ADDR = 5'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_line;
    logic        phy_o = 1'b1;
    logic        phy_oe = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    // Pulled-up shared line
    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_master uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_line)
    );

    // ---------------- PHY responder model ----------------
    logic [15:0] phy_mem [32];
    int          ph_state = 0;
    int          ones = 0;
    int          fcnt = 0;
    int          frames = 0;
    int          last_pre = 0;
    int          mdc_rises = 0;
    logic [11:0] hdr = '0;
    logic [11:0] last_hdr = '0;
    logic [1:0]  ta = '0;
    logic [1:0]  last_ta = '0;
    logic [15:0] wdat = '0;
    logic [15:0] last_wdat = '0;

    initial begin
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h0101);
        phy_mem[7] = 16'h1234;
    end

    always @(posedge mdc) mdc_rises++;

    initial begin
        logic b;
        forever begin
            @(posedge mdc);
            b = mdio_line;
            case (ph_state)
                0: begin
                    if (b) ones++;
                    else if (ones >= 32) begin last_pre = ones; ph_state = 1; end
                    else ones = 0;
                end
                1: begin
                    if (b) begin ph_state = 2; fcnt = 0; hdr = '0; end
                    else begin ph_state = 0; ones = 0; end
                end
                default: begin
                    if (fcnt < 12) hdr = {hdr[10:0], b};
                    else if (fcnt < 14) ta = {ta[0], b};
                    else wdat = {wdat[14:0], b};
                    fcnt++;
                    if (fcnt == 30) begin
                        frames++;
                        last_hdr  = hdr;
                        last_ta   = ta;
                        last_wdat = wdat;
                        if (hdr[11:10] == 2'b01 && hdr[9:5] == PHY_ADDR) phy_mem[hdr[4:0]] = wdat;
                        ph_state = 0;
                        ones = 0;
                    end
                end
            endcase
        end
    end

    initial begin
        forever begin
            @(negedge mdc);
            #1;
            if (ph_state == 2 && fcnt >= 12 && hdr[11:10] == 2'b10 && hdr[9:5] == PHY_ADDR) begin
                if (fcnt == 12) phy_oe = 1'b0;
                else if (fcnt == 13) begin phy_oe = 1'b1; phy_o = 1'b0; end
                else if (fcnt < 30) begin phy_oe = 1'b1; phy_o = phy_mem[hdr[4:0]][29-fcnt]; end
                else phy_oe = 1'b0;
            end else begin
                phy_oe = 1'b0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk(input logic go, input logic wr, input logic ack,
                                       input logic [4:0] rg, input logic [4:0] ph,
                                       input logic [15:0] d);
        return {go, wr, ack, 3'b000, rg, ph, d};
    endfunction

    task automatic wait_free();
        logic [31:0] v;
        int n = 0;
        do begin brd(A_CMD, v); n++; end while (v[31] && n < 40000);
    endtask

    task automatic mdc_period(output int cyc);
        realtime t0, t1;
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        cyc = int'((t1 - t0) / 5.0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        brd(A_CTRL, v); chk("R1/R11 control after reset", v, 32'h800000FF);
        brd(A_CMD, v);  chk("R1/R2 command after reset", v, 32'h0);
        chk("R1 mdc low", {31'b0, mdc}, 32'h0);
        chk("R1 mdio released", {31'b0, mdio_oe}, 32'h0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int f0 = frames;
        bwr(A_CTRL, 32'h40000003);
        bwr(A_CMD, mk(1, 1, 0, 5'd3, PHY_ADDR, 16'hA5C3));
        repeat (3) @(negedge clk);
        brd(A_CTRL, v); chk("R6 idle bit low during frame", {31'b0, v[31]}, 32'h0);
        brd(A_CMD, v);  chk("R6 GO held during frame", {31'b0, v[31]}, 32'h1);
        wait_free();
        repeat (4) @(negedge clk);
        chk("R3 one frame sent", 32'(frames - f0), 32'd1);
        chk("R3 preamble length", 32'(last_pre), 32'd32);
        chk("R3 header op/phy/reg", {20'b0, last_hdr}, {20'b0, 2'b01, PHY_ADDR, 5'd3});
        chk("R3 write turnaround", {30'b0, last_ta}, 32'h2);
        chk("R3 write data on wire", {16'b0, last_wdat}, 32'h0000A5C3);
        brd(A_CMD, v);  chk("R2/R6 command after write", v, mk(0, 1, 0, 5'd3, PHY_ADDR, 16'hA5C3));
        brd(A_CTRL, v); chk("R6/R11 idle after write", v, 32'hC0000003);
    endtask

    task automatic t_read();
        logic [31:0] v;
        bwr(A_CMD, mk(1, 0, 0, 5'd3, PHY_ADDR, 16'h0));
        wait_free();
        brd(A_CMD, v); chk("R4/R5 read back reg3", v, mk(0, 0, 1, 5'd3, PHY_ADDR, 16'hA5C3));
        bwr(A_CMD, mk(1, 0, 0, 5'd7, PHY_ADDR, 16'hFFFF));
        wait_free();
        brd(A_CMD, v); chk("R4/R5 read back reg7", v, mk(0, 0, 1, 5'd7, PHY_ADDR, 16'h1234));
        chk("R4 read header on wire", {20'b0, last_hdr}, {20'b0, 2'b10, PHY_ADDR, 5'd7});
    endtask

    task automatic t_absent();
        logic [31:0] v;
        bwr(A_CTRL, 32'h40040003);
        bwr(A_CMD, mk(1, 0, 0, 5'd2, 5'd9, 16'h0));
        wait_free();
        brd(A_CMD, v);  chk("R5 absent PHY ack", {31'b0, v[29]}, 32'h0);
        brd(A_CTRL, v); chk("R10 fault set", v, 32'hC00C0003);
        bwr(A_CTRL, 32'h400C0003);
        brd(A_CTRL, v); chk("R10 fault cleared by W1C", v, 32'hC0040003);
        bwr(A_CTRL, 32'h40000003);
        bwr(A_CMD, mk(1, 0, 0, 5'd2, 5'd9, 16'h0));
        wait_free();
        brd(A_CTRL, v); chk("R10 no fault with fault-enable clear", v, 32'hC0000003);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int f0 = frames;
        bwr(A_CMD, mk(1, 0, 0, 5'd7, PHY_ADDR, 16'h0));
        repeat (10) @(negedge clk);
        bwr(A_CMD, mk(1, 1, 0, 5'd1, 5'd1, 16'h0));
        wait_free();
        repeat (300) @(negedge clk);
        chk("R7 no extra frame", 32'(frames - f0), 32'd1);
        brd(A_CMD, v); chk("R7 fields unchanged", v, mk(0, 0, 1, 5'd7, PHY_ADDR, 16'h1234));
    endtask

    task automatic t_disable();
        logic [31:0] v;
        int r0;
        bwr(A_CTRL, 32'h00000003);
        r0 = mdc_rises;
        bwr(A_CMD, mk(1, 0, 0, 5'd3, PHY_ADDR, 16'h0));
        repeat (200) @(negedge clk);
        brd(A_CMD, v);  chk("R9 GO pending while disabled", {31'b0, v[31]}, 32'h1);
        brd(A_CTRL, v); chk("R9 idle while disabled", v, 32'h80000003);
        chk("R9 no MDC while disabled", 32'(mdc_rises - r0), 32'd0);
        bwr(A_CTRL, 32'h40000003);
        wait_free();
        brd(A_CMD, v);  chk("R9 runs after enable", v, mk(0, 0, 1, 5'd3, PHY_ADDR, 16'hA5C3));
        bwr(A_CMD, mk(1, 1, 0, 5'd9, PHY_ADDR, 16'h0BEE));
        repeat (50) @(negedge clk);
        bwr(A_CTRL, 32'h00000003);
        wait_free();
        repeat (4) @(negedge clk);
        chk("R9 frame finishes after disable", {16'b0, phy_mem[9]}, 32'h00000BEE);
        brd(A_CTRL, v); chk("R9 idle once stopped", v, 32'h80000003);
    endtask

    task automatic t_period();
        logic [31:0] v;
        int p;
        bwr(A_CTRL, 32'h40000001);
        bwr(A_CMD, mk(1, 0, 0, 5'd3, PHY_ADDR, 16'h0));
        mdc_period(p); chk("R8 period div=1", 32'(p), 32'd2);
        wait_free();
        brd(A_CMD, v); chk("R4/R8 read at fastest MDC", v, mk(0, 0, 1, 5'd3, PHY_ADDR, 16'hA5C3));
        bwr(A_CTRL, 32'h40000000);
        bwr(A_CMD, mk(1, 0, 0, 5'd7, PHY_ADDR, 16'h0));
        mdc_period(p); chk("R8 period div=0 acts as 1", 32'(p), 32'd2);
        wait_free();
        brd(A_CMD, v); chk("R4/R8 read at div=0", v, mk(0, 0, 1, 5'd7, PHY_ADDR, 16'h1234));
        bwr(A_CTRL, 32'h40000006);
        bwr(A_CMD, mk(1, 1, 0, 5'd4, PHY_ADDR, 16'h5A5A));
        mdc_period(p); chk("R8 period div=6", 32'(p), 32'd7);
        wait_free();
        repeat (8) @(negedge clk);
        chk("R3/R8 write at div=6", {16'b0, phy_mem[4]}, 32'h00005A5A);
        chk("R8 mdc low when idle", {31'b0, mdc}, 32'h0);
        bwr(A_CTRL, 32'h400000FF);
        bwr(A_CMD, mk(1, 0, 0, 5'd4, PHY_ADDR, 16'h0));
        mdc_period(p); chk("R8 period div=255", 32'(p), 32'd256);
        wait_free();
        brd(A_CMD, v); chk("R4/R8 read at div=255", v, mk(0, 0, 1, 5'd4, PHY_ADDR, 16'h5A5A));
    endtask

    // ---------------- sequencing ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_absent();
        t_busy_ignore();
        t_disable();
        t_period();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule